// File: doc/BRIEF.md
# Persistent Quadrature Position Counter Engine

This engine sits behind a serial memory slave. It carries out counting commands on a six-byte state record that is held in the memory array. The serial front end decodes an opcode and presents it on `cmd_op` with a one-cycle `cmd_valid` strobe. The engine then runs its own sequence:

1. It reads the six bytes of the record.
2. It evaluates the command against the stored state.
3. It writes the record back, unless the command is refused.

While the sequence runs, the 2-bit `status` code gives the front end a value to shift out during its dummy clocks.

There are two modes.

- **Position mode.** The opcode carries a fresh direction/pulse sample. The engine compares this sample with the sample stored earlier. A fixed transition table gives the result: the 43-bit signed count goes up by one, goes down by one, or stays the same. The new sample is then stored, and the direction bit is also copied into a redundant shadow bit.
- **Binary mode.** Increment and decrement commands act on a 46-bit signed count kept in the same six bytes.

In both modes two sticky error flags record overflow and underflow. While either flag is set, every later command is refused. The flags are cleared only when the host rewrites the bytes through a normal memory write.

The controller has five states:

| State | Cycles | Action | Next state |
|---|---|---|---|
| IDLE | until accept | Waits for a recognised opcode | FETCH, when a recognised opcode arrives |
| FETCH | 6 | Reads bytes 0 to 5 | CALC, after the sixth read |
| CALC | 1 | Decides whether the command is refused | FINISH if refused, otherwise STORE |
| STORE | 6 | Writes bytes 0 to 5 | FINISH, after the sixth write |
| FINISH | 1 | Posts the result code | IDLE |

Top module: `qpc_engine`

## Requirements
- R1: Opcodes 30h to 33h select position mode, with the new direction in opcode bit 1 and the new pulse in opcode bit 0. Opcode 3Ch selects binary increment and 3Eh selects binary decrement. Any other opcode is ignored: `busy` stays low, memory is not written and `status` keeps its value.
- R2: In position mode the count rises by one for these transitions from old (dir,pulse) to new (dir,pulse): (0,1)→(0,0), (1,1)→(0,0), (1,0)→(0,0) and (1,1)→(0,1).
- R3: In position mode the count falls by one for (1,0)→(1,1), (0,0)→(1,1), (0,1)→(1,1) and (0,0)→(1,0). All other transitions leave the count unchanged. Every accepted position command stores the new pair and copies the new direction into the shadow bit.
- R4: The position record is laid out as follows:
  - byte 0 holds count[5:0] in bits 7:2, direction in bit 1 and pulse in bit 0;
  - bytes 1 to 4 hold count[37:6], least significant byte first;
  - byte 5 holds the flags in bits 7:6 (overflow = 01, underflow = 10), the shadow direction in bit 5 and count[42:38] in bits 4:0.
- R5: The binary record is laid out as follows: bytes 0 to 4 hold count[39:0], least significant byte first, and byte 5 holds the flags in bits 7:6 and count[45:40] in bits 5:0. Opcodes 3Ch and 3Eh add and subtract one.
- R6: A command is refused when the stored flags are not 00, or, in position mode, when the stored direction differs from the shadow bit. A refused command writes no byte and ends with `status` = 11.
- R7: Incrementing from the largest count (2^42−1 in position mode, 2^45−1 in binary mode) sets the flags to 01 and leaves the count unchanged.
- R8: Decrementing from the smallest count (−2^42 in position mode, −2^45 in binary mode) sets the flags to 10 and leaves the count unchanged. The engine never writes flags 11.
- R9: While `busy` is high, `status` reads 00 and new commands are ignored. An accepted command keeps `busy` high for 14 cycles and ends with `status` = 01. A refused command keeps `busy` high for 8 cycles.
- R10: Counts are two's complement. A decrement from zero gives all ones, and an increment from −1 gives zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | One-cycle strobe for a decoded opcode |
| cmd_op | input | 8 | Opcode byte |
| busy | output | 1 | High while a command is in progress |
| status | output | 2 | Result code: 00 working, 01 done, 11 refused |
| mem_addr | output | ADDR_W | Byte address into the memory array |
| mem_we | output | 1 | Write strobe for `mem_wdata` |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read at `mem_addr` in the same cycle |

## Verification
The assertions check on every cycle that:
- `status` stays 00 while `busy` is high;
- no write strobe appears after a refusal;
- a recognised opcode always starts a sequence;
- a finished sequence posts 01 or 11;
- a raised flag never comes with a changed count;
- the flags are never written as 11.

Only the bench scenarios can show the rest: the exact transition table, byte placement of both records, the count boundaries, two's-complement wrap through zero, sticky-flag refusal, and the handling of ignored and overlapping opcodes. The bench checks each of these against records it builds and decodes byte by byte.

// File: rtl/qpc_pkg.sv
package qpc_pkg;
    localparam int NBYTES   = 6;
    localparam int BYTE_W   = 8;
    localparam int FLAT_W   = NBYTES * BYTE_W;
    localparam int POS_W    = 43;
    localparam int BIN_W    = 46;
    localparam int POS_LSB  = 2;
    localparam int SHDW_BIT = 45;
    localparam int FLAG_LSB = 46;
    localparam int IDX_W    = $clog2(NBYTES);

    localparam logic [7:0] OP_POS_BASE = 8'h30;
    localparam logic [7:0] OP_BIN_UP   = 8'h3C;
    localparam logic [7:0] OP_BIN_DN   = 8'h3E;

    localparam logic [1:0] FLAG_OK    = 2'b00;
    localparam logic [1:0] FLAG_OVER  = 2'b01;
    localparam logic [1:0] FLAG_UNDER = 2'b10;

    typedef enum logic [1:0] {
        MODE_POS,
        MODE_UP,
        MODE_DN
    } mode_t;
endpackage

// File: rtl/qpc_decode.sv
module qpc_decode
    import qpc_pkg::*;
(
    input  logic [7:0] op,
    output logic       known,
    output mode_t      mode,
    output logic       new_dir,
    output logic       new_pulse
);
    always_comb begin
        known     = 1'b1;
        mode      = MODE_POS;
        new_dir   = op[1];
        new_pulse = op[0];
        if (op[7:2] == OP_POS_BASE[7:2]) begin
            mode = MODE_POS;
        end else if (op == OP_BIN_UP) begin
            mode = MODE_UP;
        end else if (op == OP_BIN_DN) begin
            mode = MODE_DN;
        end else begin
            known = 1'b0;
        end
    end
endmodule

// File: rtl/qpc_step.sv
module qpc_step
    import qpc_pkg::*;
(
    input  mode_t             mode,
    input  logic              new_dir,
    input  logic              new_pulse,
    input  logic [FLAT_W-1:0] rd_flat,
    output logic [FLAT_W-1:0] wr_flat,
    output logic              refuse
);
    localparam logic [POS_W-1:0] POS_MAX = {1'b0, {(POS_W-1){1'b1}}};
    localparam logic [POS_W-1:0] POS_MIN = {1'b1, {(POS_W-1){1'b0}}};
    localparam logic [BIN_W-1:0] BIN_MAX = {1'b0, {(BIN_W-1){1'b1}}};
    localparam logic [BIN_W-1:0] BIN_MIN = {1'b1, {(BIN_W-1){1'b0}}};

    logic [1:0]       flags;
    logic [3:0]       pair_move;
    logic             pos_up, pos_dn;
    logic [POS_W-1:0] pcnt;
    logic [BIN_W-1:0] bcnt;

    assign flags     = rd_flat[FLAG_LSB +: 2];
    assign pair_move = {rd_flat[1:0], new_dir, new_pulse};
    assign pcnt      = rd_flat[POS_LSB +: POS_W];
    assign bcnt      = rd_flat[BIN_W-1:0];

    always_comb begin
        pos_up = 1'b0;
        pos_dn = 1'b0;
        unique case (pair_move)
            4'b0100, 4'b1100, 4'b1000, 4'b1101: pos_up = 1'b1;
            4'b1011, 4'b0011, 4'b0111, 4'b0010: pos_dn = 1'b1;
            default: ;
        endcase
    end

    always_comb begin
        wr_flat = rd_flat;
        refuse  = (flags != FLAG_OK);
        if (mode == MODE_POS) begin
            refuse = refuse || (rd_flat[1] != rd_flat[SHDW_BIT]);
            wr_flat[1:0]     = {new_dir, new_pulse};
            wr_flat[SHDW_BIT] = new_dir;
            if (pos_up && pcnt == POS_MAX)
                wr_flat[FLAG_LSB +: 2] = FLAG_OVER;
            else if (pos_dn && pcnt == POS_MIN)
                wr_flat[FLAG_LSB +: 2] = FLAG_UNDER;
            else
                wr_flat[POS_LSB +: POS_W] = pcnt + POS_W'(pos_up) - POS_W'(pos_dn);
        end else if (mode == MODE_UP) begin
            if (bcnt == BIN_MAX) wr_flat[FLAG_LSB +: 2] = FLAG_OVER;
            else                 wr_flat[BIN_W-1:0]     = bcnt + 1'b1;
        end else begin
            if (bcnt == BIN_MIN) wr_flat[FLAG_LSB +: 2] = FLAG_UNDER;
            else                 wr_flat[BIN_W-1:0]     = bcnt - 1'b1;
        end
    end
endmodule

// File: rtl/qpc_engine.sv
module qpc_engine
    import qpc_pkg::*;
#(
    parameter int                ADDR_W    = 11,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_op,
    output logic              busy,
    output logic [1:0]        status,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBYTES - 1);

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_CALC,
        S_STORE,
        S_FINISH
    } state_t;

    state_t            st, st_nx;
    logic [IDX_W-1:0]  idx;
    logic [FLAT_W-1:0] rd_flat, wr_flat;
    mode_t             mode_q, dec_mode;
    logic              dir_q, pulse_q, dec_dir, dec_pulse, dec_known;
    logic              refuse, rej_q;
    logic [1:0]        status_q;
    logic              accept;

    qpc_decode u_dec (
        .op        (cmd_op),
        .known     (dec_known),
        .mode      (dec_mode),
        .new_dir   (dec_dir),
        .new_pulse (dec_pulse)
    );

    qpc_step u_step (
        .mode      (mode_q),
        .new_dir   (dir_q),
        .new_pulse (pulse_q),
        .rd_flat   (rd_flat),
        .wr_flat   (wr_flat),
        .refuse    (refuse)
    );

    assign accept = (st == S_IDLE) && cmd_valid && dec_known;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:   if (accept) st_nx = S_FETCH;
            S_FETCH:  if (idx == LAST_IDX) st_nx = S_CALC;
            S_CALC:   st_nx = refuse ? S_FINISH : S_STORE;
            S_STORE:  if (idx == LAST_IDX) st_nx = S_FINISH;
            S_FINISH: st_nx = S_IDLE;
            default:  st_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx      <= '0;
            rd_flat  <= '0;
            mode_q   <= MODE_POS;
            dir_q    <= 1'b0;
            pulse_q  <= 1'b0;
            rej_q    <= 1'b0;
            status_q <= 2'b00;
        end else begin
            if (accept) begin
                mode_q   <= dec_mode;
                dir_q    <= dec_dir;
                pulse_q  <= dec_pulse;
                rej_q    <= 1'b0;
                status_q <= 2'b00;
                idx      <= '0;
            end
            if (st == S_FETCH) begin
                rd_flat[int'(idx)*BYTE_W +: BYTE_W] <= mem_rdata;
                idx <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
            end
            if (st == S_STORE)
                idx <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
            if (st == S_CALC)
                rej_q <= refuse;
            if (st == S_FINISH)
                status_q <= rej_q ? 2'b11 : 2'b01;
        end
    end

    always_comb begin
        busy      = (st != S_IDLE);
        status    = status_q;
        mem_addr  = BASE_ADDR + ADDR_W'(idx);
        mem_we    = (st == S_STORE);
        mem_wdata = wr_flat[int'(idx)*BYTE_W +: BYTE_W];
    end

    assert_status_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> status == 2'b00);
    assert_done_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (status == 2'b01 || status == 2'b11));
    assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && dec_known) |=> busy);
    assert_no_write_on_refuse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !rej_q);
    assert_hold_on_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_STORE && wr_flat[FLAG_LSB +: 2] != FLAG_OK)
        |-> wr_flat[SHDW_BIT-1:POS_LSB] == rd_flat[SHDW_BIT-1:POS_LSB]);
    assert_flag_never_11_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st == S_STORE |-> wr_flat[FLAG_LSB +: 2] != 2'b11);
endmodule

// File: tb/sim_qpc_engine.sv
`timescale 1ns/1ps
module sim_qpc_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_op = 8'h00;
    logic        busy;
    logic [1:0]  status;
    logic [10:0] mem_addr;
    logic        mem_we;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;

    logic [7:0]  mem [0:7];
    logic        tb_load = 1'b0;
    logic [47:0] tb_image = '0;

    int n_chk = 0;
    int n_fail = 0;
    int busy_len;

    always #2.5 clk = ~clk;

    qpc_engine u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .busy(busy), .status(status), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    assign mem_rdata = (mem_addr < 11'd8) ? mem[mem_addr[2:0]] : 8'h00;

    always @(posedge clk) begin
        if (mem_we && mem_addr < 11'd8)
            mem[mem_addr[2:0]] <= mem_wdata;
        else if (tb_load)
            for (int i = 0; i < 6; i++) mem[i] <= tb_image[8*i +: 8];
    end

    function automatic logic [47:0] pos_rec(logic [42:0] c, logic d, logic p,
                                            logic dc, logic [1:0] ef);
        logic [7:0] b0, b1, b2, b3, b4, b5;
        b0 = {c[5:0], d, p};
        b1 = c[13:6];
        b2 = c[21:14];
        b3 = c[29:22];
        b4 = c[37:30];
        b5 = {ef, dc, c[42:38]};
        return {b5, b4, b3, b2, b1, b0};
    endfunction

    function automatic logic [47:0] bin_rec(logic [45:0] c, logic [1:0] ef);
        logic [7:0] b5;
        b5 = {ef, c[45:40]};
        return {b5, c[39:32], c[31:24], c[23:16], c[15:8], c[7:0]};
    endfunction

    function automatic logic [47:0] mem_image();
        return {mem[5], mem[4], mem[3], mem[2], mem[1], mem[0]};
    endfunction

    task automatic check(string req, logic [47:0] act, logic [47:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(logic [47:0] img);
        @(negedge clk);
        tb_image = img;
        tb_load  = 1'b1;
        @(negedge clk);
        tb_load  = 1'b0;
    endtask

    task automatic run(logic [7:0] op, logic [7:0] mid_op, bit inject);
        @(negedge clk);
        cmd_op    = op;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        busy_len  = 0;
        while (busy && busy_len < 100) begin
            busy_len++;
            if (inject && busy_len == 3) begin
                cmd_op    = mid_op;
                cmd_valid = 1'b1;
            end else begin
                cmd_valid = 1'b0;
            end
            @(negedge clk);
        end
        cmd_valid = 1'b0;
    endtask

    task automatic t_reset();
        check("R9 reset busy", {47'd0, busy}, 48'd0);
        check("R9 reset status", {46'd0, status}, 48'd0);
        check("R9 reset we", {47'd0, mem_we}, 48'd0);
    endtask

    task automatic t_pos_up();
        load(pos_rec(43'd5, 1'b0, 1'b1, 1'b0, 2'b00));
        run(8'h30, 8'h33, 1'b1);
        check("R2 R4 (0,1)->(0,0) +1", mem_image(), pos_rec(43'd6, 1'b0, 1'b0, 1'b0, 2'b00));
        check("R9 busy length done", 48'(busy_len), 48'd14);
        check("R9 status done", {46'd0, status}, 48'd1);
        load(pos_rec('1, 1'b1, 1'b1, 1'b1, 2'b00));
        run(8'h31, 8'h00, 1'b0);
        check("R2 R10 (1,1)->(0,1) -1 to 0", mem_image(), pos_rec(43'd0, 1'b0, 1'b1, 1'b0, 2'b00));
        load(pos_rec(43'd100, 1'b1, 1'b0, 1'b1, 2'b00));
        run(8'h30, 8'h00, 1'b0);
        check("R2 (1,0)->(0,0) +1", mem_image(), pos_rec(43'd101, 1'b0, 1'b0, 1'b0, 2'b00));
    endtask

    task automatic t_pos_dn();
        load(pos_rec(43'd0, 1'b0, 1'b0, 1'b0, 2'b00));
        run(8'h33, 8'h00, 1'b0);
        check("R3 R10 (0,0)->(1,1) 0-1", mem_image(), pos_rec('1, 1'b1, 1'b1, 1'b1, 2'b00));
        load(pos_rec(43'h155_5555_5555, 1'b0, 1'b0, 1'b0, 2'b00));
        run(8'h32, 8'h00, 1'b0);
        check("R3 R4 (0,0)->(1,0) -1", mem_image(),
              pos_rec(43'h155_5555_5554, 1'b1, 1'b0, 1'b1, 2'b00));
        load(pos_rec(43'd7, 1'b0, 1'b0, 1'b0, 2'b00));
        run(8'h31, 8'h00, 1'b0);
        check("R3 (0,0)->(0,1) no change", mem_image(), pos_rec(43'd7, 1'b0, 1'b1, 1'b0, 2'b00));
    endtask

    task automatic t_refuse();
        logic [47:0] img;
        img = pos_rec(43'd9, 1'b1, 1'b0, 1'b0, 2'b00);
        load(img);
        run(8'h30, 8'h00, 1'b0);
        check("R6 shadow mismatch untouched", mem_image(), img);
        check("R6 status refused", {46'd0, status}, 48'd3);
        check("R9 busy length refused", 48'(busy_len), 48'd8);
        img = bin_rec(46'd3, 2'b11);
        load(img);
        run(8'h3C, 8'h00, 1'b0);
        check("R6 flagged record untouched", mem_image(), img);
    endtask

    task automatic t_bounds();
        load(pos_rec({1'b0, {42{1'b1}}}, 1'b0, 1'b1, 1'b0, 2'b00));
        run(8'h30, 8'h00, 1'b0);
        check("R7 position overflow", mem_image(),
              pos_rec({1'b0, {42{1'b1}}}, 1'b0, 1'b0, 1'b0, 2'b01));
        run(8'h33, 8'h00, 1'b0);
        check("R6 sticky flag refuses", {46'd0, status}, 48'd3);
        load(bin_rec({1'b1, 45'd0}, 2'b00));
        run(8'h3E, 8'h00, 1'b0);
        check("R8 binary underflow", mem_image(), bin_rec({1'b1, 45'd0}, 2'b10));
        load(pos_rec({1'b1, 42'd0}, 1'b1, 1'b0, 1'b1, 2'b00));
        run(8'h33, 8'h00, 1'b0);
        check("R8 position underflow", mem_image(), pos_rec({1'b1, 42'd0}, 1'b1, 1'b1, 1'b1, 2'b10));
        load(bin_rec({1'b0, {45{1'b1}}}, 2'b00));
        run(8'h3C, 8'h00, 1'b0);
        check("R7 binary overflow", mem_image(), bin_rec({1'b0, {45{1'b1}}}, 2'b01));
    endtask

    task automatic t_binary();
        load(bin_rec(46'h0AB_CDEF_12FF, 2'b00));
        run(8'h3C, 8'h00, 1'b0);
        check("R5 binary increment", mem_image(), bin_rec(46'h0AB_CDEF_1300, 2'b00));
        load(bin_rec(46'd0, 2'b00));
        run(8'h3E, 8'h00, 1'b0);
        check("R5 R10 binary 0-1", mem_image(), bin_rec('1, 2'b00));
    endtask

    task automatic t_ignore();
        logic [47:0] img;
        img = bin_rec(46'd42, 2'b00);
        load(img);
        @(negedge clk);
        cmd_op    = 8'h34;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R1 unknown opcode no busy", {47'd0, busy}, 48'd0);
        repeat (20) @(negedge clk);
        check("R1 unknown opcode memory", mem_image(), img);
        check("R1 unknown opcode status", {46'd0, status}, 48'd1);
    endtask

    initial begin
        #(5.0 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_pos_up();
        t_pos_dn();
        t_refuse();
        t_bounds();
        t_binary();
        t_ignore();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule